// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block keeps stores in program order from the moment they are allocated until each one has been written to the data cache. A store gets a slot and an age tag at allocation. Its address and its data are filled in later, in either order, through two separate write ports that carry that tag. A commit strobe marks the oldest uncommitted store as committed. Committed stores whose address and data are both known are offered to the cache one at a time, oldest first.

The same block answers load lookups. A load carries an age tag, which is the allocation tag that was current when the load was dispatched. Only stores allocated before that point count as older. The lookup answer arrives one cycle after the request and is one of three results. A bypass means the load may read the cache. A forward returns the data of the youngest older store that writes every byte the load needs. A stall means the load must retry later. Addresses are word addresses with a byte mask. When the caller only has the untranslated page-offset bits, it flags the lookup as offset-only. In that case a match can never be forwarded.

A flush discards every store that has not committed yet. The stores that were already committed still drain to the cache.

Top module: `store_buffer`

## Requirements
- R1: `allocTag` is the tag the next allocated store receives. It advances by one, modulo 2^(log2(DEPTH)+1), on each cycle where `allocValid` and `allocReady` are both high. `allocReady` is low while DEPTH stores are held or while `flush` is high, and an allocation request at such a time leaves `allocTag` unchanged.
- R2: Address (with byte mask) and data of a store are written by tag through independent ports, in either order or in the same cycle.
- R3: `drainValid` is high only when the oldest held store has committed and has both address and data. Stores drain strictly in tag order. A store held while `drainReady` is low stays offered unchanged.
- R4: A lookup returns kind 2 (stall) if any store older than the load has no address yet.
- R5: If every older store has a known address and none overlaps the load, the result is kind 0 (bypass). Overlap means the same word address and at least one common mask bit.
- R6: Otherwise, if the youngest overlapping older store has its data and its mask covers every byte of the load mask, the result is kind 1 (forward) and `respData` carries that store's data word.
- R7: If the youngest overlapping older store lacks data, or covers only part of the load mask, the result is kind 2 (stall).
- R8: Only stores whose tags lie between the oldest held store and the load tag are considered. Stores allocated at or after the load tag, and stores already drained, are ignored.
- R9: In offset-only mode only the low PAGE_W address bits are compared. Any overlap gives kind 2 and never kind 1. No overlap gives kind 0.
- R10: `flush` removes every uncommitted store and rewinds `allocTag` to the first removed tag. Committed stores still drain.
- R11: `respValid` is high exactly in the cycle after a cycle with `ldReq` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Request to allocate a store slot |
| allocReady | output | 1 | Slot free and no flush this cycle |
| allocTag | output | PTR_W | Tag given to the next allocated store |
| stAddrValid | input | 1 | Store address write strobe |
| stAddrTag | input | PTR_W | Tag of the store whose address is written |
| stAddr | input | ADDR_W | Store word address |
| stMask | input | MASK_W | Store byte mask |
| stDataValid | input | 1 | Store data write strobe |
| stDataTag | input | PTR_W | Tag of the store whose data is written |
| stData | input | DATA_W | Store data word |
| commit | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Discard all uncommitted stores |
| ldReq | input | 1 | Load lookup request |
| ldTag | input | PTR_W | Allocation tag current at load dispatch |
| ldAddr | input | ADDR_W | Load word address |
| ldMask | input | MASK_W | Load byte mask |
| ldOfsOnly | input | 1 | Only page-offset bits of ldAddr are meaningful |
| respValid | output | 1 | Lookup result valid |
| respKind | output | 2 | 0 bypass, 1 forward, 2 stall |
| respData | output | DATA_W | Forwarded data (zero otherwise) |
| drainValid | output | 1 | Oldest store offered to the cache |
| drainReady | input | 1 | Cache accepts the offered store |
| drainTag | output | PTR_W | Tag of the offered store |
| drainAddr | output | ADDR_W | Address of the offered store |
| drainMask | output | MASK_W | Byte mask of the offered store |
| drainData | output | DATA_W | Data of the offered store |

## Verification
The assertions check the following on every cycle:
- response timing;
- that offset-only lookups never forward;
- that a load with no older store bypasses;
- that the allocation tag steps by one and is refused at full occupancy;
- that a drained store is held while the cache stalls and is followed by the next tag.

Only the bench scenarios can show the value-dependent results. These are the choice of the youngest matching store, partial-mask stalls, the age cut-off between two stores at the same address, the forwarded data words, and the drain sequence and allocation tag after a flush.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    LD_BYPASS  = 2'd0,
    LD_FORWARD = 2'd1,
    LD_STALL   = 2'd2
  } ld_kind_e;

  typedef struct packed {
    logic allocFire;
    logic drainFire;
  } sb_strobe_t;

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  output logic             allocReady,
  input  logic             commit,
  input  logic             flush,
  input  logic             drainReady,
  input  logic             headReady,
  output logic             drainValid,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output sb_strobe_t       strb
);

  logic [PTR_W-1:0] commitPtr;
  logic [PTR_W-1:0] commitNext;
  logic [PTR_W-1:0] liveCnt;
  logic             isFull;
  logic             commitFire;

  assign liveCnt    = tailPtr - headPtr;
  assign isFull     = (liveCnt == PTR_W'(DEPTH));
  assign allocReady = !isFull && !flush;
  assign commitFire = commit && (commitPtr != tailPtr);
  assign commitNext = commitPtr + PTR_W'(commitFire);
  assign drainValid = (headPtr != commitPtr) && headReady;

  always_comb begin
    strb = '0;
    strb.allocFire = allocValid && allocReady;
    strb.drainFire = drainValid && drainReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      commitPtr <= '0;
    end else begin
      commitPtr <= commitNext;
      if (strb.drainFire) headPtr <= headPtr + PTR_W'(1);
      if (flush)               tailPtr <= commitNext;
      else if (strb.allocFire) tailPtr <= tailPtr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/sb_data.sv
module sb_data
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 10,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sb_strobe_t        strb,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic              stAddrValid,
  input  logic [PTR_W-1:0]  stAddrTag,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [MASK_W-1:0] stMask,
  input  logic              stDataValid,
  input  logic [PTR_W-1:0]  stDataTag,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldReq,
  input  logic [PTR_W-1:0]  ldTag,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [MASK_W-1:0] ldMask,
  input  logic              ldOfsOnly,
  output logic              headReady,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [MASK_W-1:0] drainMask,
  output logic [DATA_W-1:0] drainData,
  output logic              respValid,
  output logic [1:0]        respKind,
  output logic [DATA_W-1:0] respData
);

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [MASK_W-1:0] maskQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0]  aVld;
  logic [DEPTH-1:0]  dVld;

  logic [PTR_W-1:0] liveCnt;
  logic [PTR_W-1:0] addrDist;
  logic [PTR_W-1:0] dataDist;
  logic [PTR_W-1:0] ldDist;
  logic [PTR_W-1:0] olderCnt;
  logic             addrLive;
  logic             dataLive;
  logic [IDX_W-1:0] tailIdx;
  logic [IDX_W-1:0] headIdx;

  assign liveCnt  = tailPtr - headPtr;
  assign addrDist = stAddrTag - headPtr;
  assign dataDist = stDataTag - headPtr;
  assign ldDist   = ldTag - headPtr;
  assign addrLive = stAddrValid && (addrDist < liveCnt);
  assign dataLive = stDataValid && (dataDist < liveCnt);
  assign olderCnt = (ldDist <= liveCnt) ? ldDist : '0;
  assign tailIdx  = tailPtr[IDX_W-1:0];
  assign headIdx  = headPtr[IDX_W-1:0];

  // Per-slot overlap against the load: word address plus shared byte.
  logic [DEPTH-1:0] slotOvl;
  logic [DEPTH-1:0] slotCover;
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic addrEq;
    assign addrEq = ldOfsOnly ? (addrQ[g][PAGE_W-1:0] == ldAddr[PAGE_W-1:0])
                              : (addrQ[g] == ldAddr);
    assign slotOvl[g]   = aVld[g] && addrEq && (|(maskQ[g] & ldMask));
    assign slotCover[g] = dVld[g] && ((maskQ[g] & ldMask) == ldMask);
  end

  // Walk older stores oldest to youngest; the last overlap seen wins.
  logic             anyUnknown;
  logic             hitAny;
  logic [IDX_W-1:0] hitSlot;
  logic [PTR_W-1:0] walkPos;
  logic [IDX_W-1:0] walkSlot;
  ld_kind_e         kindNext;

  always_comb begin
    anyUnknown = 1'b0;
    hitAny     = 1'b0;
    hitSlot    = '0;
    walkPos    = '0;
    walkSlot   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      walkPos  = headPtr + PTR_W'(k);
      walkSlot = walkPos[IDX_W-1:0];
      if (PTR_W'(k) < olderCnt) begin
        if (!aVld[walkSlot]) anyUnknown = 1'b1;
        if (slotOvl[walkSlot]) begin
          hitAny  = 1'b1;
          hitSlot = walkSlot;
        end
      end
    end
    if (anyUnknown)              kindNext = LD_STALL;
    else if (!hitAny)            kindNext = LD_BYPASS;
    else if (ldOfsOnly)          kindNext = LD_STALL;
    else if (slotCover[hitSlot]) kindNext = LD_FORWARD;
    else                         kindNext = LD_STALL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aVld      <= '0;
      dVld      <= '0;
      respValid <= 1'b0;
      respKind  <= LD_BYPASS;
      respData  <= '0;
    end else begin
      if (strb.allocFire) begin
        aVld[tailIdx] <= 1'b0;
        dVld[tailIdx] <= 1'b0;
      end
      if (addrLive) aVld[stAddrTag[IDX_W-1:0]] <= 1'b1;
      if (dataLive) dVld[stDataTag[IDX_W-1:0]] <= 1'b1;
      respValid <= ldReq;
      respKind  <= kindNext;
      respData  <= (kindNext == LD_FORWARD) ? dataQ[hitSlot] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (addrLive) begin
      addrQ[stAddrTag[IDX_W-1:0]] <= stAddr;
      maskQ[stAddrTag[IDX_W-1:0]] <= stMask;
    end
    if (dataLive) dataQ[stDataTag[IDX_W-1:0]] <= stData;
  end

  assign headReady = aVld[headIdx] && dVld[headIdx];
  assign drainAddr = addrQ[headIdx];
  assign drainMask = maskQ[headIdx];
  assign drainData = dataQ[headIdx];

endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 10,
  localparam int PTR_W  = $clog2(DEPTH) + 1,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  output logic              allocReady,
  output logic [PTR_W-1:0]  allocTag,
  input  logic              stAddrValid,
  input  logic [PTR_W-1:0]  stAddrTag,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [MASK_W-1:0] stMask,
  input  logic              stDataValid,
  input  logic [PTR_W-1:0]  stDataTag,
  input  logic [DATA_W-1:0] stData,
  input  logic              commit,
  input  logic              flush,
  input  logic              ldReq,
  input  logic [PTR_W-1:0]  ldTag,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [MASK_W-1:0] ldMask,
  input  logic              ldOfsOnly,
  output logic              respValid,
  output logic [1:0]        respKind,
  output logic [DATA_W-1:0] respData,
  output logic              drainValid,
  input  logic              drainReady,
  output logic [PTR_W-1:0]  drainTag,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [MASK_W-1:0] drainMask,
  output logic [DATA_W-1:0] drainData
);

  sb_strobe_t       strb;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic             headReady;

  sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .allocValid(allocValid),
    .allocReady(allocReady),
    .commit    (commit),
    .flush     (flush),
    .drainReady(drainReady),
    .headReady (headReady),
    .drainValid(drainValid),
    .headPtr   (headPtr),
    .tailPtr   (tailPtr),
    .strb      (strb)
  );

  sb_data #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .headPtr    (headPtr),
    .tailPtr    (tailPtr),
    .stAddrValid(stAddrValid),
    .stAddrTag  (stAddrTag),
    .stAddr     (stAddr),
    .stMask     (stMask),
    .stDataValid(stDataValid),
    .stDataTag  (stDataTag),
    .stData     (stData),
    .ldReq      (ldReq),
    .ldTag      (ldTag),
    .ldAddr     (ldAddr),
    .ldMask     (ldMask),
    .ldOfsOnly  (ldOfsOnly),
    .headReady  (headReady),
    .drainAddr  (drainAddr),
    .drainMask  (drainMask),
    .drainData  (drainData),
    .respValid  (respValid),
    .respKind   (respKind),
    .respData   (respData)
  );

  assign allocTag = tailPtr;
  assign drainTag = headPtr;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [PTR_W-1:0] allocTag,
  input logic             ldReq,
  input logic [PTR_W-1:0] ldTag,
  input logic             ldOfsOnly,
  input logic             respValid,
  input logic [1:0]       respKind,
  input logic             drainValid,
  input logic             drainReady,
  input logic [PTR_W-1:0] drainTag
);

  // R11
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq |=> respValid);

  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldReq |=> !respValid);

  // R9
  ofs_no_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq && ldOfsOnly |=> respKind != 2'd1);

  // R8
  no_older_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq && (ldTag == drainTag) |=> respKind == 2'd0);

  // R1
  alloc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && allocReady |=> allocTag == ($past(allocTag) + PTR_W'(1)));

  // R1
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PTR_W'(allocTag - drainTag) == PTR_W'(DEPTH)) |-> !allocReady);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainValid && !drainReady |=> drainValid && $stable(drainTag));

  // R3
  drain_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainValid && drainReady |=> drainTag == ($past(drainTag) + PTR_W'(1)));

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_sbChk (
  .clk       (clk),
  .rstN      (rstN),
  .allocValid(allocValid),
  .allocReady(allocReady),
  .allocTag  (allocTag),
  .ldReq     (ldReq),
  .ldTag     (ldTag),
  .ldOfsOnly (ldOfsOnly),
  .respValid (respValid),
  .respKind  (respKind),
  .drainValid(drainValid),
  .drainReady(drainReady),
  .drainTag  (drainTag)
);

// File: tb/tb_store_buffer.sv
`timescale 1ns/1ps
module tb_store_buffer;

  localparam int PTR_W = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 0, stAddrValid = 0, stDataValid = 0, commit = 0, flush = 0;
  logic ldReq = 0, ldOfsOnly = 0, drainReady = 0;
  logic [PTR_W-1:0] stAddrTag = '0, stDataTag = '0, ldTag = '0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [MW-1:0] stMask = '0, ldMask = '0;
  logic [DW-1:0] stData = '0;
  logic allocReady, respValid, drainValid;
  logic [PTR_W-1:0] allocTag, drainTag;
  logic [1:0] respKind;
  logic [DW-1:0] respData, drainData;
  logic [AW-1:0] drainAddr;
  logic [MW-1:0] drainMask;

  always #4 clk = ~clk;

  store_buffer dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
    .allocTag(allocTag), .stAddrValid(stAddrValid), .stAddrTag(stAddrTag),
    .stAddr(stAddr), .stMask(stMask), .stDataValid(stDataValid),
    .stDataTag(stDataTag), .stData(stData), .commit(commit), .flush(flush),
    .ldReq(ldReq), .ldTag(ldTag), .ldAddr(ldAddr), .ldMask(ldMask),
    .ldOfsOnly(ldOfsOnly), .respValid(respValid), .respKind(respKind),
    .respData(respData), .drainValid(drainValid), .drainReady(drainReady),
    .drainTag(drainTag), .drainAddr(drainAddr), .drainMask(drainMask),
    .drainData(drainData)
  );

  int nTests = 0;
  int nFails = 0;
  bit finished = 0;

  logic [1:0]  expKind [$];
  logic [DW-1:0] expData [$];
  string       expReq  [$];
  logic [PTR_W-1:0] expDrTag [$];
  logic [AW-1:0]    expDrAddr [$];
  logic [DW-1:0]    expDrData [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doAlloc();
    allocValid = 1; tick(); allocValid = 0;
  endtask

  task automatic wrAddr(input logic [PTR_W-1:0] t, input logic [AW-1:0] a,
                        input logic [MW-1:0] m);
    stAddrValid = 1; stAddrTag = t; stAddr = a; stMask = m;
    tick(); stAddrValid = 0;
  endtask

  task automatic wrData(input logic [PTR_W-1:0] t, input logic [DW-1:0] d);
    stDataValid = 1; stDataTag = t; stData = d;
    tick(); stDataValid = 0;
  endtask

  task automatic doCommit(input logic [PTR_W-1:0] t, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
    expDrTag.push_back(t); expDrAddr.push_back(a); expDrData.push_back(d);
    commit = 1; tick(); commit = 0;
  endtask

  // Driver: push the expected result, then issue the lookup for one cycle.
  task automatic doLoad(input logic [PTR_W-1:0] t, input logic [AW-1:0] a,
                        input logic [MW-1:0] m, input bit ofs,
                        input logic [1:0] k, input logic [DW-1:0] d,
                        input string req);
    expKind.push_back(k); expData.push_back(d); expReq.push_back(req);
    ldReq = 1; ldTag = t; ldAddr = a; ldMask = m; ldOfsOnly = ofs;
    tick(); ldReq = 0; ldOfsOnly = 0;
  endtask

  // Monitor: lookup responses and drained stores.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (respValid) begin
        if (expKind.size() == 0) begin
          check(0, "R11 unexpected response", 64'(respKind), 64'd0);
        end else begin
          logic [1:0] k;
          logic [DW-1:0] d;
          string r;
          k = expKind.pop_front(); d = expData.pop_front(); r = expReq.pop_front();
          check(respKind == k, {r, " kind"}, 64'(respKind), 64'(k));
          if (k == 2'd1) check(respData == d, {r, " data"}, 64'(respData), 64'(d));
        end
      end
      if (drainValid && drainReady) begin
        if (expDrTag.size() == 0) begin
          check(0, "R3 unexpected drain", 64'(drainTag), 64'd0);
        end else begin
          logic [PTR_W-1:0] t;
          logic [AW-1:0] a;
          logic [DW-1:0] d;
          t = expDrTag.pop_front(); a = expDrAddr.pop_front(); d = expDrData.pop_front();
          check(drainTag == t, "R3 drain tag", 64'(drainTag), 64'(t));
          check(drainAddr == a, "R3 drain addr", 64'(drainAddr), 64'(a));
          check(drainData == d, "R3 drain data", 64'(drainData), 64'(d));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFails++; nTests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // Reset state (R1, R3, R11)
    check(allocReady == 1, "R1 reset allocReady", 64'(allocReady), 64'd1);
    check(allocTag == 0, "R1 reset allocTag", 64'(allocTag), 64'd0);
    check(drainValid == 0, "R3 reset drainValid", 64'(drainValid), 64'd0);
    check(respValid == 0, "R11 reset respValid", 64'(respValid), 64'd0);

    doAlloc();                                   // tag 0
    doLoad(1, 32'h100, 4'hF, 0, 2'd2, 0, "R4 addr unknown");
    wrData(0, 32'hAAAA0001);                      // data before address (R2)
    doLoad(1, 32'h100, 4'hF, 0, 2'd2, 0, "R4 addr still unknown");
    wrAddr(0, 32'h100, 4'hF);
    doLoad(1, 32'h100, 4'hF, 0, 2'd1, 32'hAAAA0001, "R6 R2 forward");
    doLoad(1, 32'h200, 4'hF, 0, 2'd0, 0, "R5 no match");
    doLoad(0, 32'h100, 4'hF, 0, 2'd0, 0, "R8 no older store");

    doAlloc();                                   // tag 1
    wrAddr(1, 32'h100, 4'hF);
    doLoad(2, 32'h100, 4'hF, 0, 2'd2, 0, "R7 data missing");
    wrData(1, 32'hBBBB0002);
    doLoad(2, 32'h100, 4'hF, 0, 2'd1, 32'hBBBB0002, "R6 youngest");
    doLoad(1, 32'h100, 4'hF, 0, 2'd1, 32'hAAAA0001, "R8 age cut");

    doAlloc();                                   // tag 2
    wrAddr(2, 32'h300, 4'h3);
    wrData(2, 32'hCCCC0003);
    doLoad(3, 32'h300, 4'hF, 0, 2'd2, 0, "R7 partial");
    doLoad(3, 32'h300, 4'h1, 0, 2'd1, 32'hCCCC0003, "R6 covered bytes");
    doLoad(3, 32'h300, 4'hC, 0, 2'd0, 0, "R5 disjoint bytes");
    doLoad(3, 32'h5100, 4'hF, 1, 2'd2, 0, "R9 offset match");
    doLoad(3, 32'h7200, 4'hF, 1, 2'd0, 0, "R9 offset no match");
    doLoad(3, 32'h5100, 4'hF, 0, 2'd0, 0, "R5 full compare differs");

    // Drain only after commit, held while not ready (R3)
    check(drainValid == 0, "R3 uncommitted not offered", 64'(drainValid), 64'd0);
    commit = 1; tick(); commit = 0;
    #1;
    check(drainValid == 1 && drainTag == 0, "R3 offered", 64'(drainTag), 64'd0);
    tick();
    check(drainValid == 1 && drainTag == 0, "R3 held", 64'(drainTag), 64'd0);
    expDrTag.push_back(0); expDrAddr.push_back(32'h100); expDrData.push_back(32'hAAAA0001);
    drainReady = 1;
    doCommit(1, 32'h100, 32'hBBBB0002);
    flush = 1; tick(); flush = 0;
    repeat (3) tick();
    check(allocTag == 2, "R10 tag rewind", 64'(allocTag), 64'd2);
    check(drainValid == 0, "R10 flushed not drained", 64'(drainValid), 64'd0);
    doLoad(2, 32'h100, 4'hF, 0, 2'd0, 0, "R8 R10 all drained");

    // Fill to full (R1)
    for (int i = 0; i < 8; i++) doAlloc();
    check(allocReady == 0, "R1 full", 64'(allocReady), 64'd0);
    doAlloc();
    check(allocTag == 10, "R1 refused alloc", 64'(allocTag), 64'd10);
    for (int i = 0; i < 8; i++) begin
      wrData(PTR_W'(2 + i), 32'hD000 + i);
      wrAddr(PTR_W'(2 + i), 32'h400 + i, 4'hF);
    end
    for (int i = 0; i < 8; i++) doCommit(PTR_W'(2 + i), 32'h400 + i, 32'hD000 + i);
    repeat (4) tick();
    check(allocReady == 1, "R1 space after drain", 64'(allocReady), 64'd1);
    check(expDrTag.size() == 0, "R3 all drained", 64'(expDrTag.size()), 64'd0);
    check(expKind.size() == 0, "R11 all responses", 64'(expKind.size()), 64'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule